// File: doc/BRIEF.md
# Clock Generator Configuration Slave

This block is a two-wire serial slave that holds the configuration bytes of a clock generator. A bus master writes the bytes in one block transfer. The master sends the write address and then two header bytes, a command code and a count. The slave acknowledges both header bytes and discards their contents. The data bytes that follow fill register 0, then register 1, and so on upward, until the master issues STOP. A read transfer returns the same registers in the same order, always starting at register 0.

There is no register addressing. The block does no clock stretching. SDA and SCL are sampled by the fast system clock through synchronizers. The register contents go out in parallel to the clock logic. The two low bits of register 0 are also presented as a decoded output-mode field.

A power-down input takes the slave off the bus: it stops driving SDA, it ignores all bus activity, and it keeps every register unchanged.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: The slave acknowledges only the address byte 0xD2 (7-bit address 0x69 with R/W=0, write) and the address byte 0xD3 (R/W=1, read). Any other address byte gets no ACK, and the slave then ignores the bus until the next START.
- R2: In a write, the slave acknowledges the two bytes that follow the address byte. Their values change no register.
- R3: In a write, data bytes load register 0, 1, 2, ... in ascending order. A STOP after any complete byte leaves every register that was not reached unchanged.
- R4: In a write, data bytes beyond the last implemented register (NUM_REGS, 6 by default) are acknowledged and discarded.
- R5: A read returns register 0 first, then each following register in ascending order. Every byte beyond the last register reads as 0xFF. A master NACK ends the read.
- R6: After reset, register 0 holds 0x00 and every other register holds 0xFF.
- R7: out_mode equals bits [1:0] of register 0, with this encoding: 0 = normal, 1 = test clock, 2 = spread spectrum, 3 = all outputs high impedance.
- R8: While pd_req is high, the slave does not drive SDA and ignores all bus activity. No register changes. After pd_req falls, the slave answers the next transfer that starts with START.
- R9: For every byte it accepts, the slave pulls SDA low for the ninth SCL pulse. The slave only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_req | input | 1 | Power-down request: releases SDA and freezes the registers |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When high, the SDA pad pulls the line low (open drain) |
| cfg_bytes | output | 8*NUM_REGS | Register contents; register i is in bits [8i+7:8i] |
| out_mode | output | 2 | Output-mode field taken from register 0 bits [1:0] |

## Verification
The bench sweeps write lengths from zero through two bytes past the last register. This catches a pointer that does not start at register 0, a header byte that is stored, a write that wraps around into register 0, and a missing ACK on an overflow byte. Reads run past the end of the bank, so a design that wraps or repeats the last register returns the wrong bytes. Wrong addresses, and power-down asserted both before and in the middle of a transfer, must leave the registers intact and SDA released; a slave that keeps decoding during power-down would acknowledge or corrupt a register.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RX,
        PH_RX_ACK,
        PH_TX,
        PH_TX_ACK
    } phase_e;

    typedef enum logic [1:0] {
        OM_NORMAL = 2'd0,
        OM_TEST   = 2'd1,
        OM_SPREAD = 2'd2,
        OM_HIZ    = 2'd3
    } out_mode_e;

    localparam logic [1:0] HDR_ADDR = 2'd0;
    localparam logic [1:0] HDR_DATA = 2'd3;
    localparam logic [7:0] EMPTY_BYTE = 8'hFF;

endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
    parameter int LINES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] cur_o,
    output logic [LINES-1:0] prv_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic s1_q, s2_q, s3_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= 1'b1;
                s2_q <= 1'b1;
                s3_q <= 1'b1;
            end else begin
                s1_q <= raw_i[g];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end
        assign cur_o[g] = s2_q;
        assign prv_o[g] = s3_q;
    end
endmodule

// File: rtl/clkcfg_reg_bank.sv
module clkcfg_reg_bank
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS = 6,
    localparam int IDX_W = $clog2(NUM_REGS + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [7:0]            rd_data,
    output logic [8*NUM_REGS-1:0] bytes_o
);
    logic [7:0] mem_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] RST_VAL = (g == 0) ? 8'h00 : 8'hFF;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_q[g] <= RST_VAL;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                mem_q[g] <= wr_data;
        end
        assign bytes_o[8*g +: 8] = mem_q[g];
    end

    always_comb begin
        rd_data = EMPTY_BYTE;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_idx == IDX_W'(i)) rd_data = mem_q[i];
    end
endmodule

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int         NUM_REGS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pd_req,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [8*NUM_REGS-1:0] cfg_bytes,
    output logic [1:0]            out_mode
);
    localparam int PTR_W = $clog2(NUM_REGS + 1);

    typedef struct packed {
        phase_e           ph;
        logic [3:0]       bitcnt;
        logic [7:0]       shreg;
        logic [1:0]       hdr;
        logic             is_read;
        logic             nack;
        logic [PTR_W-1:0] ptr;
        logic             sda_oe;
    } st_t;

    st_t st_d, st_q;

    logic [1:0] cur, prv;
    logic scl_s, sda_s, scl_p, sda_p;
    logic scl_rise, scl_fall, bus_start, bus_stop;
    logic wr_en;
    logic [7:0] rd_data;

    clkcfg_line_sync #(.LINES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({scl_i, sda_i}),
        .cur_o (cur),
        .prv_o (prv)
    );

    assign {scl_s, sda_s} = cur;
    assign {scl_p, sda_p} = prv;
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
    assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;

    clkcfg_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (st_q.ptr),
        .wr_data (st_q.shreg),
        .rd_idx  (st_q.ptr),
        .rd_data (rd_data),
        .bytes_o (cfg_bytes)
    );

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        if (pd_req) begin
            st_d.ph     = PH_IDLE;
            st_d.sda_oe = 1'b0;
        end else if (bus_start) begin
            st_d.ph     = PH_RX;
            st_d.bitcnt = 4'd0;
            st_d.hdr    = HDR_ADDR;
            st_d.sda_oe = 1'b0;
        end else if (bus_stop) begin
            st_d.ph     = PH_IDLE;
            st_d.sda_oe = 1'b0;
        end else begin
            unique case (st_q.ph)
                PH_RX: begin
                    if (scl_rise && st_q.bitcnt != 4'd8) begin
                        st_d.shreg  = {st_q.shreg[6:0], sda_s};
                        st_d.bitcnt = st_q.bitcnt + 4'd1;
                    end else if (scl_fall && st_q.bitcnt == 4'd8) begin
                        st_d.sda_oe = 1'b1;
                        st_d.ph     = PH_RX_ACK;
                        if (st_q.hdr == HDR_ADDR) begin
                            st_d.is_read = st_q.shreg[0];
                            st_d.ptr     = '0;
                            if (st_q.shreg[7:1] != DEV_ADDR) begin
                                st_d.sda_oe = 1'b0;
                                st_d.ph     = PH_IDLE;
                            end
                        end else if (st_q.hdr == HDR_DATA &&
                                     st_q.ptr < PTR_W'(NUM_REGS)) begin
                            wr_en    = 1'b1;
                            st_d.ptr = st_q.ptr + 1'b1;
                        end
                        if (st_q.hdr != HDR_DATA) st_d.hdr = st_q.hdr + 2'd1;
                    end
                end
                PH_RX_ACK, PH_TX_ACK: begin
                    if (scl_rise) st_d.nack = sda_s;
                    if (scl_fall) begin
                        st_d.sda_oe = 1'b0;
                        st_d.bitcnt = 4'd0;
                        if (st_q.ph == PH_TX_ACK && st_q.nack) begin
                            st_d.ph = PH_IDLE;
                        end else if (st_q.is_read) begin
                            st_d.ph     = PH_TX;
                            st_d.shreg  = rd_data;
                            st_d.sda_oe = ~rd_data[7];
                            if (st_q.ptr < PTR_W'(NUM_REGS))
                                st_d.ptr = st_q.ptr + 1'b1;
                        end else begin
                            st_d.ph = PH_RX;
                        end
                    end
                end
                PH_TX: begin
                    if (scl_fall) begin
                        if (st_q.bitcnt == 4'd7) begin
                            st_d.sda_oe = 1'b0;
                            st_d.nack   = 1'b1;
                            st_d.ph     = PH_TX_ACK;
                        end else begin
                            st_d.bitcnt = st_q.bitcnt + 4'd1;
                            st_d.shreg  = {st_q.shreg[6:0], 1'b0};
                            st_d.sda_oe = ~st_q.shreg[6];
                        end
                    end
                end
                default: st_d.sda_oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe   = st_q.sda_oe;
    assign out_mode = cfg_bytes[1:0];
endmodule

// File: rtl/clkcfg_serial_slave_chk.sv
module clkcfg_serial_slave_chk #(
    parameter int NUM_REGS = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pd_req,
    input logic                  scl_i,
    input logic                  sda_oe,
    input logic [8*NUM_REGS-1:0] cfg_bytes
);
    logic [8*NUM_REGS-1:0] dflt;
    logic [8*NUM_REGS-1:0] prev_q;
    logic                  seen_q;
    logic [NUM_REGS-1:0]   chg;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cmp
        assign dflt[8*g +: 8] = (g == 0) ? 8'h00 : 8'hFF;
        assign chg[g] = prev_q[8*g +: 8] != cfg_bytes[8*g +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            seen_q <= 1'b0;
        end else begin
            prev_q <= cfg_bytes;
            seen_q <= 1'b1;
        end
    end

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> cfg_bytes == dflt); // R6

    AST_PD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |=> !sda_oe); // R8

    AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |=> $stable(cfg_bytes)); // R8

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i); // R9

    AST_ONE_REG_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> $countones(chg) <= 1); // R3

endmodule

bind clkcfg_serial_slave clkcfg_serial_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pd_req    (pd_req),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .cfg_bytes (cfg_bytes)
);

// File: tb/tb_clkcfg_serial_slave.sv
module tb_clkcfg_serial_slave;
    localparam int NREG = 6;
    localparam int Q    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_req = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [8*NREG-1:0] cfg_bytes;
    logic [1:0] out_mode;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] exp_r [NREG];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    clkcfg_serial_slave #(.DEV_ADDR(7'h69), .NUM_REGS(NREG)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_req    (pd_req),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .cfg_bytes (cfg_bytes),
        .out_mode  (out_mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tq();
        sda_m = 1'b0; tq();
        scl_m = 1'b0; tq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tq();
        scl_m = 1'b1; tq();
        sda_m = 1'b1; tq(); tq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tq();
            scl_m = 1'b1; tq(); tq();
            scl_m = 1'b0; tq();
        end
        sda_m = 1'b1; tq();
        scl_m = 1'b1; tq();
        ack = sda_line; tq();
        scl_m = 1'b0; tq();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tq();
            scl_m = 1'b1; tq();
            b[i] = sda_line; tq();
            scl_m = 1'b0; tq();
        end
        sda_m = nack; tq();
        scl_m = 1'b1; tq(); tq();
        scl_m = 1'b0; tq();
        sda_m = 1'b1;
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++)
            chk(req, int'(cfg_bytes[8*i +: 8]), int'(exp_r[i]));
    endtask

    // write: address, header pair, n data bytes seed + k*0x1D
    task automatic wr_txn(input logic [7:0] addr, input int n,
                          input logic [7:0] seed, input logic addr_nack);
        logic ack;
        bus_start();
        send_byte(addr, ack);
        chk("R1 address ack", int'(ack), int'(addr_nack));
        if (!ack) begin
            send_byte(8'hA5, ack);
            chk("R2 command ack", int'(ack), 0);
            send_byte(8'h3C, ack);
            chk("R2 count ack", int'(ack), 0);
            for (int k = 0; k < n; k++) begin
                logic [7:0] d;
                d = seed + 8'(k * 29);
                send_byte(d, ack);
                if (k < NREG) begin
                    chk("R3 data ack", int'(ack), 0);
                    exp_r[k] = d;
                end else begin
                    chk("R4 overflow ack", int'(ack), 0);
                end
            end
        end
        bus_stop();
    endtask

    task automatic rd_txn(input int n, input string req);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, ack);
        chk("R1 read address ack", int'(ack), 0);
        for (int k = 0; k < n; k++) begin
            recv_byte(k == n - 1, b);
            chk(req, int'(b), (k < NREG) ? int'(exp_r[k]) : 8'hFF);
        end
        bus_stop();
    endtask

    initial begin
        logic ack;
        exp_r[0] = 8'h00;
        for (int i = 1; i < NREG; i++) exp_r[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R6 reset contents, R7 mode field, SDA released
        check_regs("R6 reset value");
        chk("R7 reset mode", int'(out_mode), 0);
        chk("R9 idle release", int'(sda_oe), 0);

        // R3 R4 sweep of write lengths
        for (int n = 0; n <= NREG + 2; n++) begin
            wr_txn(8'hD2, n, 8'(8'h11 * (n + 1)), 1'b0);
            check_regs((n > NREG) ? "R4 overflow discard" : "R3 partial write");
        end

        // R5 readback beyond the end
        rd_txn(NREG + 3, "R5 read data");
        rd_txn(2, "R5 short read");

        // R1 foreign addresses are not answered
        wr_txn(8'hD0, 2, 8'h00, 1'b1);
        wr_txn(8'hA2, 2, 8'h00, 1'b1);
        wr_txn(8'h52, 2, 8'h00, 1'b1);
        check_regs("R1 foreign address");

        // R7 all four mode codes
        for (int m = 0; m < 4; m++) begin
            wr_txn(8'hD2, 1, {6'b101100, 2'(m)}, 1'b0);
            chk("R7 mode field", int'(out_mode), m);
        end

        // R8 power-down before a transfer
        pd_req = 1'b1; tq();
        wr_txn(8'hD2, 3, 8'h77, 1'b1);
        chk("R8 sda released", int'(sda_oe), 0);
        check_regs("R8 registers kept");
        pd_req = 1'b0; tq();
        rd_txn(NREG, "R8 read after power-down");

        // R8 power-down in the middle of a write
        bus_start();
        send_byte(8'hD2, ack);
        chk("R1 address ack", int'(ack), 0);
        send_byte(8'h00, ack);
        pd_req = 1'b1;
        send_byte(8'h00, ack);
        chk("R8 no ack in power-down", int'(ack), 1);
        send_byte(8'h5E, ack);
        chk("R8 no ack in power-down", int'(ack), 1);
        bus_stop();
        check_regs("R8 registers kept");
        pd_req = 1'b0; tq();
        wr_txn(8'hD2, 2, 8'hC3, 1'b0);
        check_regs("R8 write after power-down");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule